// File: doc/BRIEF.md
# Vector Register File with Element and Whole-Row Writes

This block stores four vector registers, each made of sixteen 16-bit bfloat16 elements, so every register is a 256-bit row. Software-style accesses load a single element at a time, while an array of parallel arithmetic lanes writes a complete result row back in one cycle. Both write paths share one 6-bit write address. The upper two bits pick the register and the lower four bits pick the element. The whole-row path disregards the element bits.

A 2-bit read select drives the complete contents of one register onto a 256-bit read bus through a combinational path. Writes commit on the rising clock edge, so a written value shows on the read bus starting in the cycle after the write. An asynchronous active-low reset clears the storage.

Top module: `vreg_bank`

## Requirements
- R1: While the reset is asserted, every element of every register reads as zero.
- R2: With only `elem_we` high at a rising edge, the register chosen by `wr_addr[5:4]` has its element `wr_addr[3:0]` replaced by `elem_wdata`. Element i occupies bits 16*i+15 down to 16*i of the row, and the other elements of that register keep their values.
- R3: An element write leaves the three registers it does not address unchanged.
- R4: With `row_we` high at a rising edge, the register chosen by `wr_addr[5:4]` is replaced by all 256 bits of `row_wdata`, whatever the value of `wr_addr[3:0]`.
- R5: A whole-row write leaves the three registers it does not address unchanged.
- R6: When `row_we` and `elem_we` are both high at the same edge, the whole-row write takes effect and the element data is discarded.
- R7: `rd_vec` shows the register selected by `rd_sel` without waiting for a clock edge. A write first becomes visible in the cycle after its edge, and not before.
- R8: At an edge where both write enables are low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| rd_sel | input | 2 | Register whose contents drive `rd_vec` |
| rd_vec | output | 256 | Full contents of the selected register |
| elem_we | input | 1 | Single-element write enable |
| wr_addr | input | 6 | [5:4] register, [3:0] element (element bits unused by row writes) |
| elem_wdata | input | 16 | Data for a single-element write |
| row_we | input | 1 | Whole-register write enable |
| row_wdata | input | 256 | Data for a whole-register write |

## Verification
The clocked properties assume that both write enables stay low while reset is asserted. They also assume that all inputs are settled at each rising edge, so that the values sampled there are the values the storage captured. The properties compare the read bus one cycle after a write only when `rd_sel` at that later edge points at the register that was written. For the hold and isolation checks they also require `rd_sel` to stay stable across the two edges. The stimulus meets these assumptions in three ways. It changes inputs only at falling edges or just after rising edges. It keeps both enables low during each reset. It leaves `rd_sel` parked on the last register between vectors, so the checks that depend on a stable `rd_sel` are exercised.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  parameter int unsigned VRF_EW    = 16;
  parameter int unsigned VRF_NREG  = 4;
  parameter int unsigned VRF_NELEM = 16;
endpackage

// File: rtl/vrf_wr_dec.sv
module vrf_wr_dec #(
  parameter int unsigned NREG  = 4,
  parameter int unsigned NELEM = 16,
  localparam int unsigned RSEL_W = $clog2(NREG),
  localparam int unsigned ESEL_W = $clog2(NELEM),
  localparam int unsigned ADDR_W = RSEL_W + ESEL_W
) (
  input  logic                   elem_we,
  input  logic                   row_we,
  input  logic [ADDR_W-1:0]      wr_addr,
  output logic [NREG-1:0]        row_hit,
  output logic [NREG*NELEM-1:0]  elem_hit
);
  logic [RSEL_W-1:0] reg_idx;
  logic [ESEL_W-1:0] elem_idx;

  assign reg_idx  = wr_addr[ADDR_W-1 -: RSEL_W];
  assign elem_idx = wr_addr[ESEL_W-1:0];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [RSEL_W-1:0] RID = RSEL_W'(r);
    logic reg_match;
    assign reg_match  = (reg_idx == RID);
    assign row_hit[r] = row_we & reg_match;
    for (genvar e = 0; e < NELEM; e++) begin : g_elem
      localparam logic [ESEL_W-1:0] EID = ESEL_W'(e);
      // row write has priority: element strobes are masked off by it
      assign elem_hit[r*NELEM + e] = elem_we & ~row_we & reg_match & (elem_idx == EID);
    end
  end
endmodule

// File: rtl/vrf_row.sv
module vrf_row #(
  parameter int unsigned EW    = 16,
  parameter int unsigned NELEM = 16,
  localparam int unsigned ROW_W = EW * NELEM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_hit,
  input  logic [NELEM-1:0]  elem_hit,
  input  logic [EW-1:0]     elem_wdata,
  input  logic [ROW_W-1:0]  row_wdata,
  output logic [ROW_W-1:0]  row_q
);
  logic             row_ce;
  logic [ROW_W-1:0] row_nxt;

  assign row_ce = row_hit | (|elem_hit);

  for (genvar e = 0; e < NELEM; e++) begin : g_nxt
    always_comb begin
      if (row_hit)
        row_nxt[e*EW +: EW] = row_wdata[e*EW +: EW];
      else if (elem_hit[e])
        row_nxt[e*EW +: EW] = elem_wdata;
      else
        row_nxt[e*EW +: EW] = row_q[e*EW +: EW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      row_q <= '0;
    else if (row_ce)
      row_q <= row_nxt;
  end
endmodule

// File: rtl/vrf_rd_mux.sv
module vrf_rd_mux #(
  parameter int unsigned NREG  = 4,
  parameter int unsigned ROW_W = 256,
  localparam int unsigned RSEL_W = $clog2(NREG)
) (
  input  logic [NREG*ROW_W-1:0] rows,
  input  logic [RSEL_W-1:0]     sel,
  output logic [ROW_W-1:0]      dout
);
  always_comb begin
    dout = rows[sel*ROW_W +: ROW_W];
  end
endmodule

// File: rtl/vreg_bank.sv
module vreg_bank #(
  parameter int unsigned EW    = vrf_pkg::VRF_EW,
  parameter int unsigned NREG  = vrf_pkg::VRF_NREG,
  parameter int unsigned NELEM = vrf_pkg::VRF_NELEM,
  localparam int unsigned ROW_W  = EW * NELEM,
  localparam int unsigned RSEL_W = $clog2(NREG),
  localparam int unsigned ADDR_W = RSEL_W + $clog2(NELEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RSEL_W-1:0] rd_sel,
  output logic [ROW_W-1:0]  rd_vec,
  input  logic              elem_we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [EW-1:0]     elem_wdata,
  input  logic              row_we,
  input  logic [ROW_W-1:0]  row_wdata
);
  logic [NREG-1:0]       row_hit;
  logic [NREG*NELEM-1:0] elem_hit;
  logic [NREG*ROW_W-1:0] rows;

  vrf_wr_dec #(.NREG(NREG), .NELEM(NELEM)) u_dec (
    .elem_we  (elem_we),
    .row_we   (row_we),
    .wr_addr  (wr_addr),
    .row_hit  (row_hit),
    .elem_hit (elem_hit)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_row
    vrf_row #(.EW(EW), .NELEM(NELEM)) u_row (
      .clk        (clk),
      .rst_n      (rst_n),
      .row_hit    (row_hit[r]),
      .elem_hit   (elem_hit[r*NELEM +: NELEM]),
      .elem_wdata (elem_wdata),
      .row_wdata  (row_wdata),
      .row_q      (rows[r*ROW_W +: ROW_W])
    );
  end

  vrf_rd_mux #(.NREG(NREG), .ROW_W(ROW_W)) u_rd (
    .rows (rows),
    .sel  (rd_sel),
    .dout (rd_vec)
  );
endmodule

// File: rtl/vreg_bank_chk.sv
module vreg_bank_chk #(
  parameter int unsigned EW    = 16,
  parameter int unsigned NREG  = 4,
  parameter int unsigned NELEM = 16,
  localparam int unsigned ROW_W  = EW * NELEM,
  localparam int unsigned RSEL_W = $clog2(NREG),
  localparam int unsigned ESEL_W = $clog2(NELEM),
  localparam int unsigned ADDR_W = RSEL_W + ESEL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RSEL_W-1:0] rd_sel,
  input logic [ROW_W-1:0]  rd_vec,
  input logic              elem_we,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [EW-1:0]     elem_wdata,
  input logic              row_we,
  input logic [ROW_W-1:0]  row_wdata
);
  logic [ESEL_W-1:0] eidx_q;
  logic [EW-1:0]     rd_elem;

  always_ff @(posedge clk) eidx_q <= wr_addr[ESEL_W-1:0];
  assign rd_elem = rd_vec[eidx_q*EW +: EW];

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (rd_vec == '0);
    end
  end

  // R4 and R6: a row write lands in full, even alongside an element write
  a_r4_row_lands: assert property (@(posedge clk) disable iff (!rst_n)
    row_we |=> ((rd_sel == $past(wr_addr[ADDR_W-1 -: RSEL_W])) -> (rd_vec == $past(row_wdata))));

  a_r2_elem_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_we && !row_we) |=> ((rd_sel == $past(wr_addr[ADDR_W-1 -: RSEL_W])) -> (rd_elem == $past(elem_wdata))));

  // R3 and R5: unaddressed registers keep their contents
  a_r5_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((elem_we || row_we) && rd_sel != wr_addr[ADDR_W-1 -: RSEL_W]) |=> ($stable(rd_sel) -> $stable(rd_vec)));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!elem_we && !row_we) |=> ($stable(rd_sel) -> $stable(rd_vec)));
endmodule

bind vreg_bank vreg_bank_chk #(.EW(EW), .NREG(NREG), .NELEM(NELEM)) u_chk (.*);

// File: tb/test_vreg_bank.sv
module test_vreg_bank;
  localparam int EW = 16, NREG = 4, NELEM = 16, ROW_W = EW * NELEM;

  typedef struct packed {
    logic        ew;
    logic        rw;
    logic [5:0]  addr;
    logic [15:0] edat;
    logic [15:0] seed;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 6'h00, 16'h0000, 16'h1000},
    '{1'b0, 1'b1, 6'h2B, 16'h0000, 16'hA000},
    '{1'b1, 1'b0, 6'h10, 16'h1234, 16'h0000},
    '{1'b1, 1'b0, 6'h1F, 16'h5678, 16'h0000},
    '{1'b1, 1'b0, 6'h27, 16'hBEEF, 16'h0000},
    '{1'b1, 1'b1, 6'h35, 16'hDEAD, 16'h3000},
    '{1'b1, 1'b0, 6'h35, 16'h0F0F, 16'h0000},
    '{1'b0, 1'b0, 6'h00, 16'hFFFF, 16'hFFFF},
    '{1'b0, 1'b1, 6'h1F, 16'h0000, 16'h7777},
    '{1'b1, 1'b0, 6'h03, 16'h0001, 16'h0000}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       rd_sel;
  logic [ROW_W-1:0] rd_vec;
  logic             elem_we;
  logic [5:0]       wr_addr;
  logic [EW-1:0]    elem_wdata;
  logic             row_we;
  logic [ROW_W-1:0] row_wdata;

  logic [ROW_W-1:0] model [NREG];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vreg_bank i_vreg_bank (.*);

  function automatic logic [ROW_W-1:0] mk_row(logic [15:0] seed);
    logic [ROW_W-1:0] v;
    for (int i = 0; i < NELEM; i++) v[i*EW +: EW] = seed + 16'(i) * 16'h1111;
    return v;
  endfunction

  task automatic chk(string tag, logic [ROW_W-1:0] act, logic [ROW_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_all(int tgt, logic ew, logic rw);
    for (int r = 0; r < NREG; r++) begin
      string tag;
      rd_sel = 2'(r);
      #1;
      if (r == tgt) tag = (rw && ew) ? "R6" : rw ? "R4" : ew ? "R2" : "R8";
      else          tag = rw ? "R5" : ew ? "R3" : "R8";
      chk(tag, rd_vec, model[r]);
    end
  endtask

  task automatic do_reset();
    elem_we = 0; row_we = 0;
    rst_n = 1'b0;
    for (int r = 0; r < NREG; r++) model[r] = '0;
    repeat (2) @(posedge clk);
    #1;
    read_all(-1, 0, 0); // R1 check via tags of idle; also explicit below
    for (int r = 0; r < NREG; r++) begin
      rd_sel = 2'(r); #1;
      chk("R1", rd_vec, '0);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; rd_sel = 0; elem_we = 0; row_we = 0;
    wr_addr = 0; elem_wdata = 0; row_wdata = 0;
    #2;
    do_reset();

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      elem_we = VECS[v].ew; row_we = VECS[v].rw; wr_addr = VECS[v].addr;
      elem_wdata = VECS[v].edat; row_wdata = mk_row(VECS[v].seed);
      @(posedge clk); #1;
      if (VECS[v].rw) model[VECS[v].addr[5:4]] = row_wdata;
      else if (VECS[v].ew) model[VECS[v].addr[5:4]][VECS[v].addr[3:0]*EW +: EW] = VECS[v].edat;
      elem_we = 0; row_we = 0;
      read_all(int'(VECS[v].addr[5:4]), VECS[v].ew, VECS[v].rw);
    end

    // R7: read select acts without a clock edge
    @(negedge clk);
    rd_sel = 2'd0; #1; chk("R7", rd_vec, model[0]);
    rd_sel = 2'd2; #1; chk("R7", rd_vec, model[2]);

    // R7: a pending element write is not visible before its edge
    elem_we = 1; wr_addr = 6'h2E; elem_wdata = 16'hC0DE;
    #1; chk("R7", rd_vec, model[2]);
    @(posedge clk); #1;
    elem_we = 0;
    model[2][14*EW +: EW] = 16'hC0DE;
    chk("R7", rd_vec, model[2]);

    // R1: reset in the middle of a run clears everything
    @(negedge clk);
    do_reset();
    // still writable after reset
    @(negedge clk);
    row_we = 1; wr_addr = 6'h3A; row_wdata = mk_row(16'h4242);
    @(posedge clk); #1;
    row_we = 0; model[3] = row_wdata;
    read_all(3, 0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule